// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block performs a quiet comparison of two IEEE-754 scalar values and reports the outcome as a four-bit condition code (N, Z, C, V). It produces no data result. A two-bit precision selector picks half, single or double width. A zero-compare control replaces the second operand with positive zero of the selected width. The unit sorts each comparison into one of four outcomes: less, equal, greater or unordered. It also raises an invalid-operation indication when a signaling NaN takes part.

The unit is a single registered stage. A request presented with `valid_i` high is captured at the next rising clock edge. The flags and the invalid indication appear on that edge together with `valid_o`. Between requests the flag outputs keep their last value, so downstream logic can sample them at any time.

Top module: `fp_cmp_flags`

## Requirements
- R1: A request with valid_i high yields nzcv_o, invalid_o and valid_o=1 after exactly one rising clock edge; valid_o is 0 in any cycle that follows a cycle with valid_i low.
- R2: The flag codes on nzcv_o (bit 3 = N, bit 0 = V) are: less 4'b1000, equal 4'b0110, greater 4'b0010, unordered 4'b0011.
- R3: prec_i selects the format. 2'b11 is half (sign bit 15, exponent [14:10], fraction [9:0]). 2'b00 is single (sign 31, exponent [30:23], fraction [22:0]). 2'b01 is double (sign 63, exponent [62:52], fraction [51:0]). The reserved code 2'b10 is handled as single. Operand bits above the selected format are ignored.
- R4: With zero_cmp_i high, the second operand is positive zero of the selected width and op_b_i has no effect on either nzcv_o or invalid_o.
- R5: Positive zero and negative zero compare equal.
- R6: An operand whose exponent is all ones and whose fraction is nonzero is a NaN; if either operand is a NaN the result is unordered.
- R7: invalid_o is 1 only when at least one operand is a signaling NaN (most significant fraction bit 0). A quiet NaN alone gives unordered with invalid_o 0.
- R8: Infinities are ordered. Negative infinity is below every finite value, positive infinity is above every finite value, and two infinities of the same sign are equal.
- R9: Ordered values follow sign-magnitude order. When both operands are negative, the larger magnitude is the smaller value.
- R10: While rst_ni is low, nzcv_o is 4'b0000, invalid_o is 0 and valid_o is 0.
- R11: While valid_i is low, nzcv_o and invalid_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| prec_i | input | 2 | Precision code (11 half, 00 single, 01 double) |
| zero_cmp_i | input | 1 | Compare the first operand against positive zero |
| op_a_i | input | 64 | First operand bit pattern, right-aligned |
| op_b_i | input | 64 | Second operand bit pattern, right-aligned |
| valid_o | output | 1 | Result strobe |
| nzcv_o | output | 4 | Condition flags N, Z, C, V |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
Signaling-NaN detection and the zero-compare substitution act in the same cycle. The bench therefore presents a signaling NaN on op_b_i while zero_cmp_i is high. In that case the unit must report the first operand's order against zero, with invalid_o low. A signaling NaN on op_a_i under zero-compare must still raise invalid_o and give the unordered code. A second overlap is reserved-code decoding together with bits above the format. The bench chooses operands whose outcome differs between single and double reading, and it puts nonzero patterns above the selected width.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int OPW = 64;
    localparam int MAGW = OPW - 1;

    typedef enum logic [1:0] {
        PREC_SGL = 2'b00,
        PREC_DBL = 2'b01,
        PREC_RSV = 2'b10,
        PREC_HLF = 2'b11
    } prec_e;

    localparam logic [3:0] FLAG_LT = 4'b1000;
    localparam logic [3:0] FLAG_EQ = 4'b0110;
    localparam logic [3:0] FLAG_GT = 4'b0010;
    localparam logic [3:0] FLAG_UN = 4'b0011;

    typedef struct packed {
        logic            sign;
        logic [MAGW-1:0] mag;
        logic            nan;
        logic            snan;
        logic            zero;
    } opnd_t;

    typedef struct packed {
        logic       valid;
        logic [3:0] nzcv;
        logic       inv;
    } state_t;

endpackage

// File: rtl/fpcmp_field.sv
module fpcmp_field
    import fpcmp_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int MW = EW + FW
) (
    input  logic [MW:0] raw_i,
    output opnd_t       opnd_o
);

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          exp_ones;
    logic          frac_nz;

    always_comb begin
        expo     = raw_i[MW-1:FW];
        frac     = raw_i[FW-1:0];
        exp_ones = &expo;
        frac_nz  = |frac;

        opnd_o            = '0;
        opnd_o.sign       = raw_i[MW];
        opnd_o.mag[MW-1:0] = raw_i[MW-1:0];
        opnd_o.nan        = exp_ones & frac_nz;
        opnd_o.snan       = exp_ones & frac_nz & ~frac[FW-1];
        opnd_o.zero       = ~|raw_i[MW-1:0];
    end

endmodule

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
#(
    parameter int HLF_EW = 5,
    parameter int HLF_FW = 10,
    parameter int SGL_EW = 8,
    parameter int SGL_FW = 23,
    parameter int DBL_EW = 11,
    parameter int DBL_FW = 52,
    localparam int NFMT = 3
) (
    input  logic [1:0]     prec_i,
    input  logic           force_zero_i,
    input  logic [OPW-1:0] raw_i,
    output opnd_t          opnd_o
);

    opnd_t fmt_opnd [NFMT];

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int EW = (g == 0) ? HLF_EW : (g == 1) ? SGL_EW : DBL_EW;
        localparam int FW = (g == 0) ? HLF_FW : (g == 1) ? SGL_FW : DBL_FW;
        fpcmp_field #(
            .EW(EW),
            .FW(FW)
        ) field_i (
            .raw_i (raw_i[EW+FW:0]),
            .opnd_o(fmt_opnd[g])
        );
    end

    always_comb begin
        unique case (prec_e'(prec_i))
            PREC_HLF: opnd_o = fmt_opnd[0];
            PREC_DBL: opnd_o = fmt_opnd[2];
            default:  opnd_o = fmt_opnd[1];
        endcase
        if (force_zero_i) begin
            opnd_o      = '0;
            opnd_o.zero = 1'b1;
        end
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t      a_i,
    input  opnd_t      b_i,
    output logic [3:0] nzcv_o,
    output logic       inv_o
);

    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a_i.mag < b_i.mag;
        mag_eq = a_i.mag == b_i.mag;
        inv_o  = a_i.snan | b_i.snan;

        if (a_i.nan || b_i.nan) begin
            nzcv_o = FLAG_UN;
        end else if (a_i.zero && b_i.zero) begin
            nzcv_o = FLAG_EQ;
        end else if (a_i.sign != b_i.sign) begin
            nzcv_o = a_i.sign ? FLAG_LT : FLAG_GT;
        end else if (mag_eq) begin
            nzcv_o = FLAG_EQ;
        end else if (mag_lt ^ a_i.sign) begin
            nzcv_o = FLAG_LT;
        end else begin
            nzcv_o = FLAG_GT;
        end
    end

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fpcmp_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        valid_i,
    input  logic [1:0]  prec_i,
    input  logic        zero_cmp_i,
    input  logic [63:0] op_a_i,
    input  logic [63:0] op_b_i,
    output logic        valid_o,
    output logic [3:0]  nzcv_o,
    output logic        invalid_o
);

    opnd_t      opnd_a;
    opnd_t      opnd_b;
    logic [3:0] cmp_nzcv;
    logic       cmp_inv;
    state_t     st_d;
    state_t     st_q;

    fpcmp_unpack unpack_a_i (
        .prec_i      (prec_i),
        .force_zero_i(1'b0),
        .raw_i       (op_a_i),
        .opnd_o      (opnd_a)
    );

    fpcmp_unpack unpack_b_i (
        .prec_i      (prec_i),
        .force_zero_i(zero_cmp_i),
        .raw_i       (op_b_i),
        .opnd_o      (opnd_b)
    );

    fpcmp_order order_i (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .nzcv_o(cmp_nzcv),
        .inv_o (cmp_inv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.nzcv = cmp_nzcv;
            st_d.inv  = cmp_inv;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.valid;
    assign nzcv_o    = st_q.nzcv;
    assign invalid_o = st_q.inv;

endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        valid_i,
    input logic        zero_cmp_i,
    input logic [63:0] op_a_i,
    input logic        valid_o,
    input logic [3:0]  nzcv_o,
    input logic        invalid_o
);

    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o); // R1

    AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o); // R1

    AST_FLAG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (nzcv_o == 4'b1000 || nzcv_o == 4'b0110 ||
                     nzcv_o == 4'b0010 || nzcv_o == 4'b0011)); // R2

    AST_INVALID_UNORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        invalid_o |-> nzcv_o == 4'b0011); // R7

    AST_ZERO_SELF_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && zero_cmp_i && op_a_i == 64'd0) |=> nzcv_o == 4'b0110); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(nzcv_o) && $stable(invalid_o))); // R11

endmodule

bind fp_cmp_flags fpcmp_chk chk_i (.*);

// File: tb/fp_cmp_flags_tb_top.sv
module fp_cmp_flags_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  prec_i = 2'b00;
    logic        zero_cmp_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic        valid_o;
    logic [3:0]  nzcv_o;
    logic        invalid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] P_H = 2'b11, P_S = 2'b00, P_D = 2'b01, P_R = 2'b10;
    localparam logic [3:0] LT = 4'b1000, EQ = 4'b0110, GT = 4'b0010, UN = 4'b0011;

    always #4 clk = ~clk;

    fp_cmp_flags dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .valid_i   (valid_i),
        .prec_i    (prec_i),
        .zero_cmp_i(zero_cmp_i),
        .op_a_i    (op_a_i),
        .op_b_i    (op_b_i),
        .valid_o   (valid_o),
        .nzcv_o    (nzcv_o),
        .invalid_o (invalid_o)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one request; checks {valid_o, nzcv_o, invalid_o} one edge later
    task automatic req(input string tag, input logic [1:0] p, input logic zc,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] exp_f, input logic exp_i);
        @(negedge clk);
        valid_i = 1'b1; prec_i = p; zero_cmp_i = zc; op_a_i = a; op_b_i = b;
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, {valid_o, nzcv_o, invalid_o}, {1'b1, exp_f, exp_i});
    endtask

    task automatic t_reset();
        check("R10", {valid_o, nzcv_o, invalid_o}, 6'b0);
    endtask

    task automatic t_codes();
        req("R2 lt", P_S, 1'b0, 64'h3F80_0000, 64'h4000_0000, LT, 1'b0);
        req("R2 gt", P_S, 1'b0, 64'h4000_0000, 64'h3F80_0000, GT, 1'b0);
        req("R2 eq", P_S, 1'b0, 64'h3F80_0000, 64'h3F80_0000, EQ, 1'b0);
    endtask

    task automatic t_latency_hold();
        req("R1 lat", P_D, 1'b0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, GT, 1'b0);
        @(negedge clk);
        check("R11 hold", {valid_o, nzcv_o, invalid_o}, {1'b0, GT, 1'b0});
        op_a_i = 64'h7FF0_0000_0000_0001;
        @(negedge clk);
        check("R11 idle", {valid_o, nzcv_o, invalid_o}, {1'b0, GT, 1'b0});
    endtask

    task automatic t_precision();
        req("R3 half", P_H, 1'b0, 64'hDEAD_BEEF_DEAD_3C00, 64'h0123_4567_89AB_4000, LT, 1'b0);
        req("R3 single", P_S, 1'b0, 64'h8000_0000_4000_0000, 64'h0000_0000_3F80_0000, GT, 1'b0);
        req("R3 double", P_D, 1'b0, 64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, LT, 1'b0);
        req("R3 reserved", P_R, 1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, LT, 1'b0);
    endtask

    task automatic t_zero();
        req("R5 signed zero", P_S, 1'b0, 64'h0000_0000, 64'h8000_0000, EQ, 1'b0);
        req("R5 half zero", P_H, 1'b0, 64'h8000, 64'h0000, EQ, 1'b0);
        req("R4 zc snan b", P_H, 1'b1, 64'hBC00, 64'h7C01, LT, 1'b0);
        req("R4 zc neg zero", P_D, 1'b1, 64'h8000_0000_0000_0000, 64'h7FF0_0000_0000_0001, EQ, 1'b0);
        req("R4 zc snan a", P_S, 1'b1, 64'h7F80_0001, 64'h3F80_0000, UN, 1'b1);
    endtask

    task automatic t_nan();
        req("R6 qnan", P_D, 1'b0, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, UN, 1'b0);
        req("R7 snan b", P_S, 1'b0, 64'h3F80_0000, 64'h7F80_0001, UN, 1'b1);
        req("R7 qnan half", P_H, 1'b0, 64'h3C00, 64'h7E00, UN, 1'b0);
        req("R7 both snan", P_H, 1'b0, 64'h7C01, 64'hFC02, UN, 1'b1);
    endtask

    task automatic t_inf_neg();
        req("R8 neg inf", P_D, 1'b0, 64'hFFF0_0000_0000_0000, 64'hC000_0000_0000_0000, LT, 1'b0);
        req("R8 pos inf", P_H, 1'b0, 64'h7C00, 64'h7BFF, GT, 1'b0);
        req("R8 inf eq", P_S, 1'b0, 64'h7F80_0000, 64'h7F80_0000, EQ, 1'b0);
        req("R9 neg dbl", P_D, 1'b0, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, LT, 1'b0);
        req("R9 neg sgl", P_S, 1'b0, 64'hBF80_0000, 64'hC000_0000, GT, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_codes();
        t_latency_hold();
        t_precision();
        t_zero();
        t_nan();
        t_inf_neg();
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule